// File: doc/BRIEF.md
# Stable Nonzero Compaction Network

This block takes a group of eight bytes and squeezes out the empty ones in a single pass. Every byte that is not zero is moved toward the low end of the group, and the bytes keep their original relative order. The freed positions at the high end are filled with zero. Alongside the packed group the block reports how many nonzero bytes it found.

Each output position has its own selector. The selector picks the input byte whose rank among the nonzero bytes equals that output position. It then steers that byte through a multiplexer whose candidate set shrinks by one with each higher position. There is one register stage that captures a group, and a second register stage that holds the packed result. A valid flag travels alongside the data through both stages.

Top module: `nz_compactor`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `out_valid` = 0, `out_data` = 0 and `out_count` = 0.
- R2: A group offered with `in_valid` high is captured at clock edge t. After edge t+1, `out_valid` is high for exactly one cycle, and the packed result for that group is on the outputs.
- R3: Element i of a group occupies bits [8i+7:8i] of `in_data`, and slot k occupies bits [8k+7:8k] of `out_data`. Nonzero elements appear in slots 0 upward, in increasing input index order, with their values unchanged.
- R4: Every slot above the last nonzero element holds zero. A zero element is treated as empty wherever it sits.
- R5: `out_count` is the number of nonzero elements in the group, in the range 0 to 8.
- R6: A group of all zeros yields all-zero `out_data` and an `out_count` of 0.
- R7: Slot 7 is nonzero only when all eight elements are nonzero, and it then carries element 7.
- R8: A clock edge with `in_valid` low captures nothing. One cycle later `out_valid` is low, and `out_data` and `out_count` keep their previous values whatever `in_data` carries.
- R9: Groups offered on consecutive cycles each produce their own result, on consecutive cycles and in the order they were offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group on `in_data` is to be captured |
| in_data | input | 64 | Eight 8-bit elements, element i at bits [8i+7:8i] |
| out_valid | output | 1 | Packed result is fresh this cycle |
| out_data | output | 64 | Eight packed slots, slot k at bits [8k+7:8k] |
| out_count | output | 4 | Number of nonzero elements in the group |

## Verification
A group driven before capture edge t has its packed slots, its count and `out_valid` due just after edge t+1. That is two rising edges after the stimulus is presented.

Each scenario task drives its inputs on a falling edge. It then waits through the capture edge and the result edge, and samples on the following falling edge, so every sample lands half a period away from the register updates.

Back-to-back groups are checked on consecutive falling edges. The hold behaviour is checked over several idle cycles in which `in_data` changes while `in_valid` stays low.

// File: rtl/compactor_pkg.sv
package compactor_pkg;
  localparam int ELEM_W   = 8;
  localparam int NUM_ELEM = 8;
endpackage

// File: rtl/compactor_rank.sv
module compactor_rank #(
  parameter int W  = 8,
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N*W-1:0]  data,
  output logic [N-1:0]    nz,
  output logic [N*CW-1:0] rank_flat,
  output logic [CW-1:0]   total
);
  // rank of element i = number of nonzero elements below it
  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      nz[i] = |data[i*W +: W];
      rank_flat[i*CW +: CW] = acc;
      acc = acc + CW'(nz[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/compactor_slot_sel.sv
module compactor_slot_sel #(
  parameter int W    = 8,
  parameter int N    = 8,
  parameter int CW   = 4,
  parameter int SLOT = 0,
  localparam int M   = N - SLOT
) (
  input  logic [M*W-1:0]  cand_data,
  input  logic [M-1:0]    cand_nz,
  input  logic [M*CW-1:0] cand_rank,
  output logic [W-1:0]    sel
);
  // candidates are inputs SLOT..N-1; at most one has rank == SLOT
  always_comb begin
    sel = '0;
    for (int j = 0; j < M; j++) begin
      if (cand_nz[j] && (cand_rank[j*CW +: CW] == CW'(SLOT)))
        sel = sel | cand_data[j*W +: W];
    end
  end
endmodule

// File: rtl/nz_compactor.sv
module nz_compactor #(
  parameter int W   = compactor_pkg::ELEM_W,
  parameter int N   = compactor_pkg::NUM_ELEM,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_data,
  output logic           out_valid,
  output logic [N*W-1:0] out_data,
  output logic [CW-1:0]  out_count
);
  logic [N*W-1:0]  in_q;
  logic            s1_valid;
  logic [N-1:0]    nz;
  logic [N*CW-1:0] rank_flat;
  logic [CW-1:0]   total;
  logic [N*W-1:0]  packed_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      in_q     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) in_q <= in_data;
    end
  end

  compactor_rank #(.W(W), .N(N), .CW(CW)) u_rank (
    .data(in_q), .nz(nz), .rank_flat(rank_flat), .total(total)
  );

  for (genvar k = 0; k < N; k++) begin : g_slot
    compactor_slot_sel #(.W(W), .N(N), .CW(CW), .SLOT(k)) u_sel (
      .cand_data(in_q[N*W-1 : k*W]),
      .cand_nz  (nz[N-1 : k]),
      .cand_rank(rank_flat[N*CW-1 : k*CW]),
      .sel      (packed_sel[k*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_count <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data  <= packed_sel;
        out_count <= total;
      end
    end
  end
endmodule

// File: rtl/nz_compactor_chk.sv
module nz_compactor_chk #(
  parameter int W   = 8,
  parameter int N   = 8,
  localparam int CW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N*W-1:0] in_data,
  input logic           out_valid,
  input logic [N*W-1:0] out_data,
  input logic [CW-1:0]  out_count
);
  logic v1, v2;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  function automatic logic [CW-1:0] nz_slots(input logic [N*W-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < N; i++) c = c + CW'(|d[i*W +: W]);
    return c;
  endfunction

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst) out_valid == v2);

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst) out_count <= CW'(N));

  // R5
  count_match_chk: assert property (@(posedge clk) disable iff (rst) nz_slots(out_data) == out_count);

  // R7
  last_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (out_data[(N-1)*W +: W] != '0) |-> (out_count == CW'(N)));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_data) && $stable(out_count)));

  for (genvar k = 0; k < N - 1; k++) begin : g_tail
    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (out_data[k*W +: W] == '0) |-> (out_data[(k+1)*W +: W] == '0));
  end
endmodule

bind nz_compactor nz_compactor_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .out_count(out_count)
);

// File: tb/nz_compactor_bench.sv
module nz_compactor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [63:0]  in_data = '0;
  logic         out_valid;
  logic [63:0]  out_data;
  logic [3:0]   out_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nz_compactor u_nz_compactor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_count(out_count)
  );

  function automatic logic [63:0] grp(input logic [7:0] e0, e1, e2, e3, e4, e5, e6, e7);
    return {e7, e6, e5, e4, e3, e2, e1, e0};
  endfunction

  function automatic logic [63:0] exp_data(input logic [63:0] d);
    logic [63:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < N; i++)
      if (d[i*W +: W] != 8'h00) begin
        r[k*W +: W] = d[i*W +: W];
        k++;
      end
    return r;
  endfunction

  function automatic logic [3:0] exp_count(input logic [63:0] d);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) if (d[i*W +: W] != 8'h00) c++;
    return 4'(c);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_result(input logic [63:0] d, input string req);
    check(out_valid == 1'b1, {req, " R2 valid"}, 64'(out_valid), 64'd1);
    check(out_data == exp_data(d), {req, " R3 data"}, out_data, exp_data(d));
    check(out_count == exp_count(d), {req, " R5 count"}, 64'(out_count), 64'(exp_count(d)));
  endtask

  // drive at negedge, capture edge, result edge, sample at next negedge
  task automatic run_group(input logic [63:0] d, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~d;
    @(negedge clk);
    check_result(d, req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0 && out_count == '0, "R1 reset",
          {out_data[59:0], out_count}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_sparse;
    run_group(grp(8'h00, 8'h04, 8'h00, 8'h00, 8'h05, 8'h00, 8'h02, 8'h00), "R3 sparse");
    check(out_data[63:24] == '0, "R4 tail zero", out_data, exp_data(out_data));
    @(negedge clk);
    check(out_valid == 1'b0, "R2 single pulse", 64'(out_valid), 64'd0);
  endtask

  task automatic t_patterns;
    run_group(grp(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h9A), "R4 only top element");
    run_group(grp(8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), "R3 only bottom element");
    run_group(grp(8'h00, 8'hFF, 8'h01, 8'h00, 8'h80, 8'h7F, 8'h00, 8'h03), "R3 mixed");
    run_group(grp(8'h01, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00), "R3 equal values");
  endtask

  task automatic t_all_zero;
    run_group('0, "R6 all zero");
    check(out_data == '0 && out_count == '0, "R6 zero output",
          out_data, 64'd0);
  endtask

  task automatic t_all_full;
    logic [63:0] d;
    d = grp(8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h88);
    run_group(d, "R7 full");
    check(out_data[63:56] == 8'h88 && out_count == 4'd8, "R7 slot7 from element 7",
          {out_data[63:56], 52'd0, out_count}, {8'h88, 52'd0, 4'd8});
    run_group(grp(8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h00, 8'h88), "R7 seven");
    check(out_data[63:56] == 8'h00, "R7 slot7 zero", 64'(out_data[63:56]), 64'd0);
  endtask

  task automatic t_idle_hold;
    logic [63:0] d;
    d = grp(8'h00, 8'hAB, 8'h00, 8'hCD, 8'h00, 8'h00, 8'h00, 8'hEF);
    run_group(d, "R8 setup");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_data = 64'h0102030405060708 + 64'(i);
      check(out_valid == 1'b0, "R8 idle valid low", 64'(out_valid), 64'd0);
      check(out_data == exp_data(d) && out_count == exp_count(d), "R8 idle hold",
            out_data, exp_data(d));
    end
  endtask

  task automatic t_back_to_back;
    logic [63:0] a, b, c;
    a = grp(8'h00, 8'h00, 8'h21, 8'h00, 8'h22, 8'h00, 8'h00, 8'h00);
    b = grp(8'h31, 8'h32, 8'h00, 8'h33, 8'h00, 8'h34, 8'h35, 8'h00);
    c = grp(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h41, 8'h42);
    @(negedge clk); in_valid = 1'b1; in_data = a;
    @(negedge clk); in_data = b;
    @(negedge clk); in_data = c;
    check_result(a, "R9 first");
    @(negedge clk); in_valid = 1'b0; in_data = '0;
    check_result(b, "R9 second");
    @(negedge clk);
    check_result(c, "R9 third");
    @(negedge clk);
    check(out_valid == 1'b0, "R9 stream end", 64'(out_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_sparse();
    t_patterns();
    t_all_zero();
    t_all_full();
    t_idle_hold();
    t_back_to_back();
    // reset mid-stream clears the outputs again
    t_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule